// File: doc/BRIEF.md
# Fixed-Count Low-Rate Averager

This block turns a stream of instantaneous metering samples into low-rate averages. Each accepted sample carries a voltage value, a current value, an instantaneous active power value and an instantaneous reactive power value. The block squares the voltage and current samples and sums all four quantities over an interval of N accepted samples. When the interval ends, it divides each sum by N in a restoring divider. It then applies the correction terms and presents the mean active power, the mean reactive power, the mean-square voltage and the mean-square current, together with a one-cycle completion strobe.

N comes from a sample-count setting. The block clamps that setting to a legal range and latches it only at interval boundaries. A new interval begins with the very next sample after the last one, so no sample is lost while the divider runs. Software can select a second averaging mode that follows line cycles. The block does not implement that mode: while it is selected, the block freezes its results and reports it as unsupported.

Top module: `lowrate_avg`

## Requirements
- R1: An interval takes exactly N accepted samples, where a sample is accepted when `smp_vld` is high and `sync_mode_sel` is low. At the end of the interval, `v_msq` equals the sum of v² divided by N, truncated. The unclamped current mean square is the sum of i² divided by N, truncated. The p and q means are the sums divided by N, truncated toward zero.
- R2: N is the `cnt_cfg` value clamped to the range [MIN_COUNT=100, MAX_COUNT=2^23]. It is latched on the clock edge that accepts the last sample of an interval and while the unsupported mode is selected. A change to `cnt_cfg` in the middle of an interval does not alter that interval.
- R3: After reset, the first interval uses N = DEFAULT_COUNT (4000), whatever `cnt_cfg` holds.
- R4: A `cnt_cfg` value below 100 gives intervals of exactly 100 samples.
- R5: `p_avg` is the p mean plus `p_off`, and `q_avg` is the q mean plus `q_off`. Each sum saturates to the signed SAMPLE_W range.
- R6: `i_msq` is the current mean square minus the unsigned `i_ac_off`, floored at zero. `v_msq` receives no offset. Offsets are sampled on the edge that registers the results.
- R7: `done` is high for exactly one cycle, ACC_W+1 clock edges after the edge that accepted the last sample, where ACC_W = 2·SAMPLE_W + log2(MAX_COUNT). The result ports change only on that edge.
- R8: Cycles with `smp_vld` low are ignored. A sample on the cycle right after an interval's last sample counts toward the next interval.
- R9: While `sync_mode_sel` is high, the following hold:
  - `unsup` is high from the next edge.
  - Samples are discarded, together with any partial interval.
  - The results and `done` do not change.
  - When the bit clears, a fresh interval starts with a newly latched N.
- R10: Under reset, all result ports, `done` and `unsup` are zero.
- R11: Full-scale samples, including the most negative code, accumulate without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe |
| v_smp | input | SAMPLE_W | Signed voltage sample |
| i_smp | input | SAMPLE_W | Signed current sample |
| p_smp | input | SAMPLE_W | Signed instantaneous active power |
| q_smp | input | SAMPLE_W | Signed instantaneous reactive power |
| cnt_cfg | input | CNT_W | Requested samples per interval |
| sync_mode_sel | input | 1 | Selects the unsupported line-synchronized mode |
| i_ac_off | input | 2·SAMPLE_W | Unsigned offset removed from the current mean square |
| p_off | input | SAMPLE_W | Signed correction added to the mean active power |
| q_off | input | SAMPLE_W | Signed correction added to the mean reactive power |
| p_avg | output | SAMPLE_W | Corrected mean active power |
| q_avg | output | SAMPLE_W | Corrected mean reactive power |
| v_msq | output | 2·SAMPLE_W | Mean-square voltage |
| i_msq | output | 2·SAMPLE_W | Corrected mean-square current |
| done | output | 1 | One-cycle result strobe |
| unsup | output | 1 | Unsupported mode is selected |

## Verification
Pseudo-random samples over a long default-length interval show that the squares and signed sums are divided correctly. Full-scale negative constants expose any wrap-around in the accumulators or in the sign handling. Alternating and ramp patterns separate truncation toward zero from flooring. Gapped strobes and back-to-back intervals show whether the sample count and the interval boundary are tied to accepted samples alone. Offsets large enough to saturate or floor, `cnt_cfg` values below the minimum or changed mid-interval, and toggles of the mode bit in the middle of an interval each produce a different result count or timing if the latching rule is wrong.

// File: rtl/lowrate_avg_pkg.sv
package lowrate_avg_pkg;

    localparam int LRA_SAMPLE_W      = 24;
    localparam int LRA_CNT_W         = 24;
    localparam int LRA_MIN_COUNT     = 100;
    localparam int LRA_DEFAULT_COUNT = 4000;
    localparam int LRA_MAX_COUNT     = 1 << 23;
    localparam int LRA_LANES         = 4;

    // lane order inside the datapath arrays
    typedef enum logic [1:0] {
        LANE_V = 2'd0,
        LANE_I = 2'd1,
        LANE_P = 2'd2,
        LANE_Q = 2'd3
    } lane_e;

    typedef enum logic {
        CTL_RUN  = 1'b0,
        CTL_HOLD = 1'b1
    } ctl_state_e;

    // per-cycle accumulator command
    typedef struct packed {
        logic take;   // add the current sample
        logic last;   // this sample closes the interval
        logic clear;  // accumulator returns to zero
    } acc_ctl_t;

    function automatic bit lane_squares(input int lane);
        return (lane == int'(LANE_V)) || (lane == int'(LANE_I));
    endfunction

endpackage

// File: rtl/lravg_ctrl.sv
module lravg_ctrl
    import lowrate_avg_pkg::*;
#(
    parameter int CNT_W         = LRA_CNT_W,
    parameter int MIN_COUNT     = LRA_MIN_COUNT,
    parameter int DEFAULT_COUNT = LRA_DEFAULT_COUNT,
    parameter int MAX_COUNT     = LRA_MAX_COUNT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_vld,
    input  logic             mode_sel,
    input  logic [CNT_W-1:0] cnt_cfg,
    output acc_ctl_t         ctl,
    output logic [CNT_W-1:0] n_cur,
    output logic             unsup
);

    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_COUNT);
    localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_COUNT);
    localparam logic [CNT_W-1:0] DEF_V = CNT_W'(DEFAULT_COUNT);

    ctl_state_e       st;
    logic [CNT_W-1:0] sc;
    logic [CNT_W-1:0] n_clamped;

    always_comb begin
        if (cnt_cfg < MIN_V)      n_clamped = MIN_V;
        else if (cnt_cfg > MAX_V) n_clamped = MAX_V;
        else                      n_clamped = cnt_cfg;
    end

    always_comb begin
        ctl.take  = smp_vld && !mode_sel;
        ctl.last  = ctl.take && (sc == n_cur - 1'b1);
        ctl.clear = ctl.last || mode_sel;
    end

    assign unsup = (st == CTL_HOLD);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= CTL_RUN;
            sc    <= '0;
            n_cur <= DEF_V;
        end else begin
            st <= mode_sel ? CTL_HOLD : CTL_RUN;
            if (mode_sel) begin
                sc    <= '0;
                n_cur <= n_clamped;
            end else if (ctl.take) begin
                if (ctl.last) begin
                    sc    <= '0;
                    n_cur <= n_clamped;
                end else begin
                    sc <= sc + 1'b1;
                end
            end
        end
    end

    // R2: the active count always lies in the legal range
    a_r2_count_in_range: assert property (@(posedge clk) disable iff (rst)
        (n_cur >= MIN_V) && (n_cur <= MAX_V));

    // R1: the sample counter never reaches the interval length
    a_r1_count_below_n: assert property (@(posedge clk) disable iff (rst)
        sc < n_cur);

    // R9: selecting the mode raises the flag on the next edge
    a_r9_unsup_follows: assert property (@(posedge clk) disable iff (rst)
        mode_sel |=> unsup);

endmodule

// File: rtl/lravg_accum.sv
module lravg_accum
    import lowrate_avg_pkg::*;
#(
    parameter int SAMPLE_W = LRA_SAMPLE_W,
    parameter int ACC_W    = 2 * LRA_SAMPLE_W + 23,
    parameter bit SQUARE   = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  acc_ctl_t                   ctl,
    input  logic signed [SAMPLE_W-1:0] smp,
    output logic signed [ACC_W-1:0]    sum_nxt
);

    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] contrib;

    generate
        if (SQUARE) begin : g_sq
            logic signed [2*SAMPLE_W-1:0] sq;
            assign sq      = smp * smp;
            assign contrib = ACC_W'(sq);

            // R11: a sum of squares never wraps into the sign bit
            a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
                !acc[ACC_W-1]);
        end else begin : g_lin
            assign contrib = ACC_W'(smp);
        end
    endgenerate

    assign sum_nxt = acc + contrib;

    always_ff @(posedge clk) begin
        if (rst)            acc <= '0;
        else if (ctl.clear) acc <= '0;
        else if (ctl.take)  acc <= sum_nxt;
    end

endmodule

// File: rtl/lravg_div.sv
module lravg_div #(
    parameter int ACC_W = 71,
    parameter int CNT_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic signed [ACC_W-1:0] dividend,
    input  logic [CNT_W-1:0]        divisor,
    output logic signed [ACC_W-1:0] quot,
    output logic                    done
);

    localparam int BC_W = $clog2(ACC_W + 1);

    logic [ACC_W-1:0] work;
    logic [CNT_W-1:0] rem;
    logic [CNT_W-1:0] dvs;
    logic             neg;
    logic             busy;
    logic [BC_W-1:0]  bitcnt;
    logic [CNT_W:0]   trial;
    logic [CNT_W:0]   diff;
    logic             fits;

    assign trial = {rem, work[ACC_W-1]};
    assign diff  = trial - {1'b0, dvs};
    assign fits  = trial >= {1'b0, dvs};
    assign quot  = neg ? -$signed(work) : $signed(work);

    always_ff @(posedge clk) begin
        if (rst) begin
            work   <= '0;
            rem    <= '0;
            dvs    <= '0;
            neg    <= 1'b0;
            busy   <= 1'b0;
            bitcnt <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                neg    <= dividend[ACC_W-1];
                work   <= dividend[ACC_W-1] ? $unsigned(-dividend) : $unsigned(dividend);
                rem    <= '0;
                dvs    <= divisor;
                bitcnt <= BC_W'(ACC_W);
                busy   <= 1'b1;
            end else if (busy) begin
                work   <= {work[ACC_W-2:0], fits};
                rem    <= fits ? diff[CNT_W-1:0] : trial[CNT_W-1:0];
                bitcnt <= bitcnt - 1'b1;
                if (bitcnt == BC_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R1: a finished division leaves a remainder below the divisor
    a_r1_rem_below_divisor: assert property (@(posedge clk) disable iff (rst)
        done |-> (rem < dvs));

    // R8: a new interval result never arrives while the previous one divides
    a_r8_start_when_idle: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R7: completion is a single-cycle event
    a_r7_done_once: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/lravg_post.sv
module lravg_post #(
    parameter int SAMPLE_W = 24,
    parameter int ACC_W    = 71
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         div_done,
    input  logic                         mode_sel,
    input  logic signed [ACC_W-1:0]      quot_v,
    input  logic signed [ACC_W-1:0]      quot_i,
    input  logic signed [ACC_W-1:0]      quot_p,
    input  logic signed [ACC_W-1:0]      quot_q,
    input  logic signed [SAMPLE_W-1:0]   p_off,
    input  logic signed [SAMPLE_W-1:0]   q_off,
    input  logic [2*SAMPLE_W-1:0]        i_ac_off,
    output logic signed [SAMPLE_W-1:0]   p_avg,
    output logic signed [SAMPLE_W-1:0]   q_avg,
    output logic [2*SAMPLE_W-1:0]        v_msq,
    output logic [2*SAMPLE_W-1:0]        i_msq,
    output logic                         done
);

    localparam int PROD_W = 2 * SAMPLE_W;
    localparam logic signed [ACC_W-1:0] S_MAX =
        {{(ACC_W-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
    localparam logic signed [ACC_W-1:0] S_MIN =
        {{(ACC_W-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};
    localparam logic signed [ACC_W-1:0] U_MAX =
        {{(ACC_W-PROD_W){1'b0}}, {PROD_W{1'b1}}};

    function automatic logic signed [SAMPLE_W-1:0] sat_s(input logic signed [ACC_W-1:0] x);
        if (x > S_MAX)      return S_MAX[SAMPLE_W-1:0];
        else if (x < S_MIN) return S_MIN[SAMPLE_W-1:0];
        return x[SAMPLE_W-1:0];
    endfunction

    function automatic logic [PROD_W-1:0] sat_u(input logic signed [ACC_W-1:0] x);
        if (x < 0)          return '0;
        else if (x > U_MAX) return '1;
        return x[PROD_W-1:0];
    endfunction

    logic signed [ACC_W-1:0] p_sum;
    logic signed [ACC_W-1:0] q_sum;
    logic signed [ACC_W-1:0] i_diff;
    logic                    commit;

    assign p_sum  = quot_p + ACC_W'(p_off);
    assign q_sum  = quot_q + ACC_W'(q_off);
    assign i_diff = quot_i - $signed(ACC_W'(i_ac_off));
    assign commit = div_done && !mode_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_avg <= '0;
            q_avg <= '0;
            v_msq <= '0;
            i_msq <= '0;
            done  <= 1'b0;
        end else begin
            done <= commit;
            if (commit) begin
                p_avg <= sat_s(p_sum);
                q_avg <= sat_s(q_sum);
                v_msq <= sat_u(quot_v);
                i_msq <= sat_u(i_diff);
            end
        end
    end

    // R9: the unsupported mode freezes every result
    a_r9_hold_in_mode: assert property (@(posedge clk) disable iff (rst)
        mode_sel |=> (!done && $stable(p_avg) && $stable(q_avg)
                      && $stable(v_msq) && $stable(i_msq)));

    // R7: results move only together with the strobe
    a_r7_results_with_done: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(p_avg) && $stable(v_msq) && $stable(i_msq)) || $past(rst));

    // R6: the current result never exceeds the uncorrected mean square
    a_r6_floor: assert property (@(posedge clk) disable iff (rst)
        commit |=> ($signed(ACC_W'(i_msq)) <= $past(quot_i)) || ($past(quot_i) > U_MAX));

endmodule

// File: rtl/lowrate_avg.sv
module lowrate_avg
    import lowrate_avg_pkg::*;
#(
    parameter int SAMPLE_W      = LRA_SAMPLE_W,
    parameter int CNT_W         = LRA_CNT_W,
    parameter int MIN_COUNT     = LRA_MIN_COUNT,
    parameter int DEFAULT_COUNT = LRA_DEFAULT_COUNT,
    parameter int MAX_COUNT     = LRA_MAX_COUNT
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         smp_vld,
    input  logic signed [SAMPLE_W-1:0]   v_smp,
    input  logic signed [SAMPLE_W-1:0]   i_smp,
    input  logic signed [SAMPLE_W-1:0]   p_smp,
    input  logic signed [SAMPLE_W-1:0]   q_smp,
    input  logic [CNT_W-1:0]             cnt_cfg,
    input  logic                         sync_mode_sel,
    input  logic [2*SAMPLE_W-1:0]        i_ac_off,
    input  logic signed [SAMPLE_W-1:0]   p_off,
    input  logic signed [SAMPLE_W-1:0]   q_off,
    output logic signed [SAMPLE_W-1:0]   p_avg,
    output logic signed [SAMPLE_W-1:0]   q_avg,
    output logic [2*SAMPLE_W-1:0]        v_msq,
    output logic [2*SAMPLE_W-1:0]        i_msq,
    output logic                         done,
    output logic                         unsup
);

    localparam int PROD_W = 2 * SAMPLE_W;
    localparam int ACC_W  = PROD_W + $clog2(MAX_COUNT);

    acc_ctl_t                   ctl;
    logic [CNT_W-1:0]           n_cur;
    logic signed [SAMPLE_W-1:0] smp_arr [LRA_LANES];
    logic signed [ACC_W-1:0]    sum_nxt [LRA_LANES];
    logic signed [ACC_W-1:0]    quot    [LRA_LANES];
    logic [LRA_LANES-1:0]       div_done;

    assign smp_arr[LANE_V] = v_smp;
    assign smp_arr[LANE_I] = i_smp;
    assign smp_arr[LANE_P] = p_smp;
    assign smp_arr[LANE_Q] = q_smp;

    lravg_ctrl #(
        .CNT_W        (CNT_W),
        .MIN_COUNT    (MIN_COUNT),
        .DEFAULT_COUNT(DEFAULT_COUNT),
        .MAX_COUNT    (MAX_COUNT)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .smp_vld (smp_vld),
        .mode_sel(sync_mode_sel),
        .cnt_cfg (cnt_cfg),
        .ctl     (ctl),
        .n_cur   (n_cur),
        .unsup   (unsup)
    );

    for (genvar g = 0; g < LRA_LANES; g++) begin : g_lane
        localparam bit SQ = lane_squares(g);

        lravg_accum #(
            .SAMPLE_W(SAMPLE_W),
            .ACC_W   (ACC_W),
            .SQUARE  (SQ)
        ) u_acc (
            .clk    (clk),
            .rst    (rst),
            .ctl    (ctl),
            .smp    (smp_arr[g]),
            .sum_nxt(sum_nxt[g])
        );

        lravg_div #(
            .ACC_W(ACC_W),
            .CNT_W(CNT_W)
        ) u_div (
            .clk     (clk),
            .rst     (rst),
            .start   (ctl.last),
            .dividend(sum_nxt[g]),
            .divisor (n_cur),
            .quot    (quot[g]),
            .done    (div_done[g])
        );
    end

    lravg_post #(
        .SAMPLE_W(SAMPLE_W),
        .ACC_W   (ACC_W)
    ) u_post (
        .clk     (clk),
        .rst     (rst),
        .div_done(&div_done),
        .mode_sel(sync_mode_sel),
        .quot_v  (quot[LANE_V]),
        .quot_i  (quot[LANE_I]),
        .quot_p  (quot[LANE_P]),
        .quot_q  (quot[LANE_Q]),
        .p_off   (p_off),
        .q_off   (q_off),
        .i_ac_off(i_ac_off),
        .p_avg   (p_avg),
        .q_avg   (q_avg),
        .v_msq   (v_msq),
        .i_msq   (i_msq),
        .done    (done)
    );

    // R7: all four lanes finish on the same edge
    a_r7_lanes_aligned: assert property (@(posedge clk) disable iff (rst)
        (div_done == '0) || (div_done == '1));

endmodule

// File: tb/lowrate_avg_bench.sv
module lowrate_avg_bench;

    localparam int CLK_PERIOD = 10;
    localparam int SW         = 16;
    localparam int PW         = 2 * SW;
    localparam int DONE_LAT   = PW + 23 + 1;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 smp_vld = 1'b0;
    logic signed [SW-1:0] v_smp = '0, i_smp = '0, p_smp = '0, q_smp = '0;
    logic [23:0]          cnt_cfg = 24'd37;
    logic                 sync_mode_sel = 1'b0;
    logic [PW-1:0]        i_ac_off = '0;
    logic signed [SW-1:0] p_off = '0, q_off = '0;
    logic signed [SW-1:0] p_avg, q_avg;
    logic [PW-1:0]        v_msq, i_msq;
    logic                 done, unsup;

    lowrate_avg #(.SAMPLE_W(SW)) u_lowrate_avg (
        .clk(clk), .rst(rst), .smp_vld(smp_vld),
        .v_smp(v_smp), .i_smp(i_smp), .p_smp(p_smp), .q_smp(q_smp),
        .cnt_cfg(cnt_cfg), .sync_mode_sel(sync_mode_sel),
        .i_ac_off(i_ac_off), .p_off(p_off), .q_off(q_off),
        .p_avg(p_avg), .q_avg(q_avg), .v_msq(v_msq), .i_msq(i_msq),
        .done(done), .unsup(unsup)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        longint p, q, v, i, at;
        string  tag;
    } exp_t;
    exp_t expq[$];

    longint sv, si, sp, sq;
    int     cnt;
    int     cur_n;
    int unsigned lcg = 32'h1234_5678;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int clamp_n(input int c);
        if (c < 100) return 100;
        if (c > (1 << 23)) return 1 << 23;
        return c;
    endfunction

    function automatic longint sat16(input longint x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    function automatic longint rnd();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return longint'($signed(lcg[30:15]));
    endfunction

    task automatic clear_model();
        sv = 0; si = 0; sp = 0; sq = 0; cnt = 0;
    endtask

    // drive one accepted sample; queue the expected result when it closes the interval
    task automatic push(input longint v, input longint i, input longint p,
                        input longint q, input string tag);
        exp_t e;
        @(negedge clk);
        smp_vld = 1'b1;
        v_smp = SW'(v); i_smp = SW'(i); p_smp = SW'(p); q_smp = SW'(q);
        sv += v * v; si += i * i; sp += p; sq += q; cnt++;
        if (cnt == cur_n) begin
            e.v = sv / cur_n;
            e.i = (si / cur_n > longint'(i_ac_off)) ? si / cur_n - longint'(i_ac_off) : 0;
            e.p = sat16(sp / cur_n + longint'(p_off));
            e.q = sat16(sq / cur_n + longint'(q_off));
            e.at = cyc + 1 + DONE_LAT;
            e.tag = tag;
            expq.push_back(e);
            cur_n = clamp_n(int'(cnt_cfg));
            clear_model();
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            smp_vld = 1'b0;
        end
    endtask

    task automatic drain();
        idle(1);
        while (expq.size() != 0) @(negedge clk);
    endtask

    // pattern 0 random, 1 full-scale negative, 2 alternating sign, 3 ramp
    task automatic run(input int n, input int pat, input int gap_pct, input string tag);
        longint v, i, p, q;
        for (int k = 0; k < n; k++) begin
            if (gap_pct > 0 && (rnd() % 100 + 100) % 100 < gap_pct) idle(1);
            case (pat)
                0: begin v = rnd(); i = rnd(); p = rnd(); q = rnd(); end
                1: begin v = -32768; i = -32768; p = -32768; q = -32768; end
                2: begin
                    v = (k % 2 == 0) ? 32767 : -32767;
                    i = (k % 2 == 0) ? -32768 : 32767;
                    p = (k % 2 == 0) ? 3 : -8;
                    q = (k % 3 == 0) ? -7 : 2;
                end
                default: begin v = k * 300 - 16000; i = 50 - k; p = k - 151; q = 77 - k; end
            endcase
            push(v, i, p, q, tag);
        end
    endtask

    // result monitor: every strobe must match a queued expectation in value and cycle
    always @(negedge clk) begin
        if (!rst && done) begin
            if (expq.size() == 0) begin
                check(1'b0, "R7", "unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check(cyc == e.at, {"R7 ", e.tag}, "done cycle", cyc, e.at);
                check(longint'(v_msq) == e.v, {"R1 ", e.tag}, "v_msq", longint'(v_msq), e.v);
                check(longint'(i_msq) == e.i, {"R6 ", e.tag}, "i_msq", longint'(i_msq), e.i);
                check(longint'(p_avg) == e.p, {"R5 ", e.tag}, "p_avg", longint'(p_avg), e.p);
                check(longint'(q_avg) == e.q, {"R5 ", e.tag}, "q_avg", longint'(q_avg), e.q);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        longint hp, hv;
        clear_model();
        cur_n = 4000;
        idle(3);
        // R10: reset state
        check(done == 0 && unsup == 0, "R10", "flags", {unsup, done}, 0);
        check(p_avg == 0 && q_avg == 0 && v_msq == 0 && i_msq == 0, "R10", "results",
              longint'(v_msq), 0);
        @(negedge clk);
        rst = 1'b0;

        // R3: first interval is 4000 samples even though cnt_cfg says 37
        run(4000, 0, 0, "R3 default count");
        drain();
        // R4: cnt_cfg 37 was latched as 100; R11 full-scale negatives
        run(100, 1, 0, "R4 R11 min count full scale");
        drain();
        // R1: alternating signs, truncation toward zero
        cnt_cfg = 24'd157;
        run(100, 2, 0, "R1 alternating");
        // R2: mid-interval change to cnt_cfg must not shorten the 157-sample interval
        run(60, 3, 0, "R2 ramp");
        cnt_cfg = 24'd211;
        run(97, 3, 0, "R2 ramp");
        drain();
        // R5/R6: saturating power offsets and floored current offset
        p_off = 16'sh7fff; q_off = -16'sh8000; i_ac_off = 32'hffff_ffff;
        run(211, 0, 0, "R5 R6 saturate");
        drain();
        p_off = -16'sd1234; q_off = 16'sd999; i_ac_off = 32'd5_000_000;
        cnt_cfg = 24'd130;
        run(211, 0, 0, "R5 R6 moderate");
        drain();
        // R8: gapped strobes, then back-to-back intervals
        run(130, 0, 40, "R8 gaps");
        run(130, 3, 0, "R8 back to back");
        run(130, 2, 25, "R8 back to back");
        drain();

        // R9: mode selected mid-interval discards the partial sums
        run(40, 0, 0, "R9 partial");
        @(negedge clk);
        sync_mode_sel = 1'b1;
        smp_vld = 1'b1;
        clear_model();
        hp = longint'(p_avg);
        hv = longint'(v_msq);
        @(negedge clk);
        check(unsup == 1'b1, "R9", "unsup", unsup, 1);
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            smp_vld = 1'b1;
            v_smp = SW'(rnd());
        end
        check(longint'(p_avg) == hp && longint'(v_msq) == hv, "R9", "results held",
              longint'(v_msq), hv);
        cnt_cfg = 24'd120;
        @(negedge clk);
        sync_mode_sel = 1'b0;
        smp_vld = 1'b0;
        cur_n = 120;
        @(negedge clk);
        check(unsup == 1'b0, "R9", "unsup cleared", unsup, 0);
        run(120, 0, 10, "R9 fresh interval");
        drain();
        idle(DONE_LAT + 5);
        check(expq.size() == 0, "R7", "pending results", expq.size(), 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule